// File: doc/BRIEF.md
# PWM Output Conditioning Stage

This block sits between a bank of PWM generators and the output pins. Every channel passes through three stages in a fixed order: an enable gate, a fault override and a polarity inversion. The pins are driven from a register clocked by the system clock. Five mask registers control these stages. All of them are loaded through one write port: the enable mask, the enable-update mode word, the fault-select mask, the fault-value mask and the invert mask.

Commutating a brushless motor comes down to one write to the enable mask. The generators themselves stay untouched. Each channel can take a new enable bit at once. It can instead hold the bit in a shadow register until the next local or global synchronous-update strobe, so that a new pattern lines up with the generator period. While the fault input is high, channels chosen for substitution drive their fault value. The inversion stage comes after the substitution, so an inverted channel drives the complement of its fault value.

Top module: `pwm_out_cond`

## Requirements
- R1: After reset every mask register, the shadow enable bits and the mode word are zero, and `pwmOut` is all zeros.
- R2: With no fault active, an enabled channel drives its `pwmIn` bit and a disabled channel drives 0, each before inversion.
- R3: In update mode 00 (immediate) or 01 (reserved, treated as immediate), a single write to the enable mask replaces the whole active set. The new set is visible on `pwmOut` one cycle after the write edge.
- R4: In update mode 10, a written enable bit is held in a shadow register. It becomes active only at a clock edge where `localSync` is high. `globalSync` has no effect on such a channel.
- R5: In update mode 11, a written enable bit becomes active only at a clock edge where `globalSync` is high. `localSync` has no effect on such a channel.
- R6: While `faultIn` is high, a channel whose fault-select bit is set drives its fault-value bit, even when that channel is disabled. Channels that are not selected keep their normal behaviour.
- R7: Inversion is applied last. A set invert bit complements the channel's output, including fault values and the 0 of a disabled channel. A channel with fault-select, fault-value and invert all set drives 0 during a fault.
- R8: `wrSel` encoding: 0 enable mask, 1 mode word, 2 fault-select mask, 3 fault-value mask, 4 invert mask. Values 5 to 7 write nothing. Mask registers take `wrData[NUM_CH-1:0]`. Channel i's mode field is `wrData[2i+1:2i]`.
- R9: `pwmOut` is registered: a change on `pwmIn` or `faultIn` reaches the pins at the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for the write |
| wrData | input | 2*NUM_CH | Write data |
| localSync | input | 1 | Local synchronous-update strobe |
| globalSync | input | 1 | Global synchronous-update strobe |
| faultIn | input | 1 | Fault condition active |
| pwmIn | input | NUM_CH | Raw PWM signals from the generators |
| pwmOut | output | NUM_CH | Conditioned signals to the pins |

## Verification
A register write or a sync strobe changes state at the edge where it is sampled, and `pwmOut` shows the result at the following edge, two edges after the stimulus is driven. A change on `pwmIn` or `faultIn` shows after a single edge. The bench drives every stimulus on a falling edge and waits the matching number of rising edges. It then samples on the next falling edge. For R9 it also samples one time unit after driving, before any edge, to confirm the old value still holds.

// File: rtl/pwm_oc_pkg.sv
package pwm_oc_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE   = 3'd0,
    SEL_MODE     = 3'd1,
    SEL_FLTSEL   = 3'd2,
    SEL_FLTVAL   = 3'd3,
    SEL_INVERT   = 3'd4
  } regSel_e;

  typedef enum logic [1:0] {
    UPD_NOW      = 2'b00,
    UPD_NOW_RSVD = 2'b01,
    UPD_LOCAL    = 2'b10,
    UPD_GLOBAL   = 2'b11
  } updMode_e;

  typedef struct packed {
    logic wrEnable;
    logic wrMode;
    logic wrFltSel;
    logic wrFltVal;
    logic wrInvert;
    logic syncLocal;
    logic syncGlobal;
  } ctlStrobe_t;
endpackage

// File: rtl/pwm_oc_ctrl.sv
module pwm_oc_ctrl
  import pwm_oc_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       localSync,
  input  logic       globalSync,
  output ctlStrobe_t stb
);
  always_comb begin
    stb = '0;
    stb.syncLocal  = localSync;
    stb.syncGlobal = globalSync;
    if (wrEn) begin
      case (wrSel)
        SEL_ENABLE: stb.wrEnable = 1'b1;
        SEL_MODE:   stb.wrMode   = 1'b1;
        SEL_FLTSEL: stb.wrFltSel = 1'b1;
        SEL_FLTVAL: stb.wrFltVal = 1'b1;
        SEL_INVERT: stb.wrInvert = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_oc_dp.sv
module pwm_oc_dp
  import pwm_oc_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int DW = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [DW-1:0]     wrData,
  input  logic              faultIn,
  input  logic [NUM_CH-1:0] pwmIn,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] activeMask,
  output logic [NUM_CH-1:0] fltSelMask,
  output logic [NUM_CH-1:0] fltValMask,
  output logic [NUM_CH-1:0] invMask
);
  logic [DW-1:0]     modeWord;
  logic [NUM_CH-1:0] shadowMask;
  logic [NUM_CH-1:0] nextActive;
  logic [NUM_CH-1:0] preOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWord   <= '0;
      shadowMask <= '0;
      fltSelMask <= '0;
      fltValMask <= '0;
      invMask    <= '0;
    end else begin
      if (stb.wrMode)   modeWord   <= wrData;
      if (stb.wrEnable) shadowMask <= wrData[NUM_CH-1:0];
      if (stb.wrFltSel) fltSelMask <= wrData[NUM_CH-1:0];
      if (stb.wrFltVal) fltValMask <= wrData[NUM_CH-1:0];
      if (stb.wrInvert) invMask    <= wrData[NUM_CH-1:0];
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
      logic [1:0] chMode;
      logic       pendBit;
      assign chMode  = modeWord[2*ch +: 2];
      assign pendBit = stb.wrEnable ? wrData[ch] : shadowMask[ch];
      assign nextActive[ch] =
          (chMode == UPD_LOCAL)  ? (stb.syncLocal  ? pendBit : activeMask[ch]) :
          (chMode == UPD_GLOBAL) ? (stb.syncGlobal ? pendBit : activeMask[ch]) :
                                   (stb.wrEnable   ? wrData[ch] : activeMask[ch]);
      assign preOut[ch] = (faultIn && fltSelMask[ch]) ? fltValMask[ch]
                                                      : (activeMask[ch] & pwmIn[ch]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMask <= '0;
      pwmOut     <= '0;
    end else begin
      activeMask <= nextActive;
      pwmOut     <= preOut ^ invMask;
    end
  end
endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond
  import pwm_oc_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [2:0]            wrSel,
  input  logic [2*NUM_CH-1:0]   wrData,
  input  logic                  localSync,
  input  logic                  globalSync,
  input  logic                  faultIn,
  input  logic [NUM_CH-1:0]     pwmIn,
  output logic [NUM_CH-1:0]     pwmOut
);
  ctlStrobe_t        stb;
  logic [NUM_CH-1:0] activeMask;
  logic [NUM_CH-1:0] fltSelMask;
  logic [NUM_CH-1:0] fltValMask;
  logic [NUM_CH-1:0] invMask;

  pwm_oc_ctrl u_ctrl (
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .localSync  (localSync),
    .globalSync (globalSync),
    .stb        (stb)
  );

  pwm_oc_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .faultIn    (faultIn),
    .pwmIn      (pwmIn),
    .pwmOut     (pwmOut),
    .activeMask (activeMask),
    .fltSelMask (fltSelMask),
    .fltValMask (fltValMask),
    .invMask    (invMask)
  );
endmodule

// File: rtl/pwm_out_cond_chk.sv
module pwm_out_cond_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrSel,
  input logic              localSync,
  input logic              globalSync,
  input logic              faultIn,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] activeMask,
  input logic [NUM_CH-1:0] fltSelMask,
  input logic [NUM_CH-1:0] fltValMask,
  input logic [NUM_CH-1:0] invMask
);
  // R1: a clock edge during reset leaves the pins quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (pwmOut == '0));

  // R2: without a fault, inactive channels drive the plain invert level
  p_disabled_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !faultIn |=> ((pwmOut & ~$past(activeMask)) == ($past(invMask) & ~$past(activeMask))));

  // R4 / R5: the active set moves only on an enable write or a sync strobe
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!localSync && !globalSync && !(wrEn && wrSel == 3'd0)) |=> $stable(activeMask));

  // R7: substituted channels show fault value xor invert
  p_fault_inv_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |=> ((pwmOut & $past(fltSelMask)) ==
                 (($past(fltValMask) ^ $past(invMask)) & $past(fltSelMask))));
endmodule

bind pwm_out_cond pwm_out_cond_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .localSync  (localSync),
  .globalSync (globalSync),
  .faultIn    (faultIn),
  .pwmOut     (pwmOut),
  .activeMask (activeMask),
  .fltSelMask (fltSelMask),
  .fltValMask (fltValMask),
  .invMask    (invMask)
);

// File: tb/pwm_out_cond_tb.sv
module pwm_out_cond_tb;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrSel = '0;
  logic [2*N-1:0] wrData = '0;
  logic          localSync = 1'b0;
  logic          globalSync = 1'b0;
  logic          faultIn = 1'b0;
  logic [N-1:0]  pwmIn = '0;
  logic [N-1:0]  pwmOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  pwm_out_cond #(.NUM_CH(N)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .localSync(localSync), .globalSync(globalSync), .faultIn(faultIn),
    .pwmIn(pwmIn), .pwmOut(pwmOut)
  );

  task automatic check(input logic [N-1:0] exp, input string tag);
    nChecks++;
    if (pwmOut !== exp) begin
      nFails++;
      $display("FAIL %s: pwmOut=%h expected=%h", tag, pwmOut, exp);
    end
  endtask

  // drive on a falling edge, hold across one rising edge
  task automatic regWrite(input logic [2:0] sel, input logic [2*N-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseSync(input logic loc, input logic glb);
    @(negedge clk);
    localSync = loc; globalSync = glb;
    @(negedge clk);
    localSync = 1'b0; globalSync = 1'b0;
  endtask

  // one more rising edge for the output register, then sample on the falling edge
  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(8'h00, "R1 reset state");
  endtask

  task automatic testPass();
    regWrite(3'd0, 16'h000F);
    @(negedge clk); pwmIn = 8'hFF;
    settle(); check(8'h0F, "R2 enabled pass, disabled low");
    @(negedge clk); pwmIn = 8'hA5;
    #1 check(8'h0F, "R9 no change before edge");
    settle(); check(8'h05, "R2 R9 new pattern after one edge");
    @(negedge clk); pwmIn = 8'hFF;
    settle();
  endtask

  task automatic testImmediate();
    regWrite(3'd0, 16'h00F0);
    settle(); check(8'hF0, "R3 immediate commutation");
    regWrite(3'd1, 16'h5555);
    regWrite(3'd0, 16'h003C);
    settle(); check(8'h3C, "R3 reserved mode acts immediately");
  endtask

  task automatic testLocal();
    regWrite(3'd1, 16'hAAAA);
    regWrite(3'd0, 16'h0081);
    settle(); check(8'h3C, "R4 held until local sync");
    pulseSync(1'b0, 1'b1);
    settle(); check(8'h3C, "R4 global ignored in local mode");
    pulseSync(1'b1, 1'b0);
    settle(); check(8'h81, "R4 committed on local sync");
  endtask

  task automatic testGlobal();
    regWrite(3'd1, 16'hFFFF);
    regWrite(3'd0, 16'h0018);
    settle(); check(8'h81, "R5 held until global sync");
    pulseSync(1'b1, 1'b0);
    settle(); check(8'h81, "R5 local ignored in global mode");
    pulseSync(1'b0, 1'b1);
    settle(); check(8'h18, "R5 committed on global sync");
  endtask

  task automatic testFault();
    regWrite(3'd1, 16'h0000);
    regWrite(3'd0, 16'h000F);
    regWrite(3'd2, 16'h0033);
    regWrite(3'd3, 16'h0021);
    settle(); check(8'h0F, "R6 no override without fault");
    @(negedge clk); faultIn = 1'b1;
    settle(); check(8'h2D, "R6 fault substitution overrides enable");
    @(negedge clk); faultIn = 1'b0;
    settle(); check(8'h0F, "R6 normal after fault clears");
  endtask

  task automatic testInvert();
    regWrite(3'd4, 16'h0081);
    settle(); check(8'h8E, "R7 inverted disabled channel drives 1");
    @(negedge clk); faultIn = 1'b1;
    settle(); check(8'hAC, "R7 inversion after fault value");
  endtask

  task automatic testSelect();
    regWrite(3'd5, 16'hFFFF);
    regWrite(3'd6, 16'hFFFF);
    regWrite(3'd7, 16'hFFFF);
    settle(); check(8'hAC, "R8 selects 5-7 write nothing");
    @(negedge clk); faultIn = 1'b0;
    regWrite(3'd1, 16'h0020);
    regWrite(3'd0, 16'h000B);
    settle(); check(8'h8E, "R8 channel 2 mode field holds its bit");
    pulseSync(1'b1, 1'b0);
    settle(); check(8'h8A, "R8 channel 2 commits on local sync");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPass();
    testImmediate();
    testLocal();
    testGlobal();
    testFault();
    testInvert();
    testSelect();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #200000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule